// File: doc/BRIEF.md
# Cascaded Interval Timer Pair

Two down-counters are chained. Counter A is a periodic rate generator. Its clock is an external blanking pulse, which arrives asynchronously to the system clock. The output of counter A is the clock of counter B. Counter B is a one-shot counter that raises its output when it reaches zero. A simple write port loads the count of either counter. Both current values and both output pins are visible at all times.

The block reproduces the load latency of a classic interval timer. A written count is not used at once. It is copied into the counting element on the next rising edge of that counter's own clock, so the first period lasts one clock longer than the later ones. Because the two counters are chained, this latency adds up. A frame-length measurement built from the pair therefore comes out a few pulses short. All state lives in the system clock domain. The blanking input passes through a two-flop synchronizer, and an edge detector qualifies every update.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset, both counts are 0, `outA` is 1 and `outB` is 0. Neither counter counts until it has been written.
- R2: A write (`wrSel`=0 selects counter A, `wrSel`=1 selects counter B) only stores the value. The first rising edge of that counter's clock after the write copies the value into the count without decrementing it.
- R3: Once loaded, counter A decrements by one on each later rising blanking edge. A rising edge that finds the count at 1 reloads the written value instead. The first period therefore lasts N+1 pulses and every later period lasts N pulses.
- R4: `outA` goes low on a falling blanking edge that finds counter A running at count 1. It goes high again on the rising edge that reloads or loads the count. A write to counter A also drives `outA` high. `outA` is never low while the count differs from 1.
- R5: A written value of 0 stands for 65536: it loads as 0, and the next decrement gives 65535.
- R6: Counter B loads or decrements only in the system cycle that follows a rising edge of `outA`.
- R7: A write to counter B drives `outB` low on the next system clock edge. `outB` goes high in the same cycle in which counter B steps from 1 to 0.
- R8: Suppose counter A is written with 2 and counter B is written before the next blanking pulse. Then counter B loads on the third rising blanking edge after the writes and makes its first decrement on the fifth.
- R9: After reaching 0, counter B keeps decrementing through 65535 and does not reload. `outB` stays high until counter B is written again.
- R10: A rewrite during counting restarts the load latency: the next clock edge loads the new value. A write in the same system cycle as a counter-clock edge takes priority over that edge.
- R11: A blanking transition sampled at a system clock edge changes counter A on the second system clock edge after that one.
- R12: A write to one counter leaves the count and output of the other counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| blankIn | input | 1 | Asynchronous blanking pulse, clock of counter A |
| wrEn | input | 1 | Write strobe for a count value |
| wrSel | input | 1 | Target of the write: 0 counter A, 1 counter B |
| wrData | input | 16 | Count value to write |
| cntA | output | 16 | Current value of counter A |
| cntB | output | 16 | Current value of counter B |
| outA | output | 1 | Rate-generator output of counter A, clock of counter B |
| outB | output | 1 | Terminal-count output of counter B |

## Verification
The assertions check several rules on every cycle. Counter A moves only after a detected rising blanking edge. Counter B moves only after a rising edge of `outA`. `outA` falls only at a falling blanking edge while its count is 1, and is never low at any other count. `outB` rises only at zero and falls only after a write to counter B. The bench scenarios are needed for the rest. The extra load pulse, the N+1 first period against the N later periods, the fifth-pulse start of counter B in the cascade, the meaning of 0 as 65536 and the wrap past zero all depend on a history of many pulses. They are compared against a behavioural model every clock and at named points.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

  // Strobes the control issues to the datapath for one system cycle
  typedef struct packed {
    logic wrA;      // store written value for counter A
    logic wrB;      // store written value for counter B
    logic loadA;    // copy stored value into counter A (first edge)
    logic decA;     // decrement counter A
    logic reloadA;  // terminal reload of counter A
    logic dropA;    // pull outA low
    logic loadB;    // copy stored value into counter B
    logic decB;     // decrement counter B
    logic setB;     // raise outB
  } ctpStrobes_t;

endpackage

// File: rtl/ctp_ctrl.sv
module ctp_ctrl
  import ctp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        blankIn,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic        outA,
  input  logic        aAtOne,
  input  logic        bAtOne,
  output ctpStrobes_t stb,
  output logic        blankRise,
  output logic        blankFall,
  output logic        outARise
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] syncQ;
  logic blankPrev;
  logic outAPrev;
  logic pendA, runA, pendB, runB;
  logic blankSync;
  logic evB;

  assign blankSync = syncQ[SYNC_MSB];
  assign blankRise = blankSync & ~blankPrev;
  assign blankFall = ~blankSync & blankPrev;
  assign outARise  = outA & ~outAPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ     <= '0;
      blankPrev <= 1'b0;
      outAPrev  <= 1'b1;
      pendA     <= 1'b0;
      runA      <= 1'b0;
      pendB     <= 1'b0;
      runB      <= 1'b0;
    end else begin
      syncQ     <= {syncQ[SYNC_MSB-1:0], blankIn};
      blankPrev <= blankSync;
      outAPrev  <= outA;
      if (stb.wrA)        pendA <= 1'b1;
      else if (stb.loadA) pendA <= 1'b0;
      if (stb.loadA)      runA  <= 1'b1;
      if (stb.wrB) begin
        pendB <= 1'b1;
        runB  <= 1'b0;
      end else if (stb.loadB) begin
        pendB <= 1'b0;
        runB  <= 1'b1;
      end
    end
  end

  always_comb begin
    stb         = '0;
    stb.wrA     = wrEn & ~wrSel;
    stb.wrB     = wrEn & wrSel;
    // counter A: a write in the same cycle overrides the clock edge
    stb.loadA   = blankRise & pendA & ~stb.wrA;
    stb.reloadA = blankRise & ~pendA & runA & aAtOne & ~stb.wrA;
    stb.decA    = blankRise & ~pendA & runA & ~aAtOne & ~stb.wrA;
    stb.dropA   = blankFall & ~pendA & runA & aAtOne & ~stb.wrA;
    // counter B is clocked by rising edges of outA
    evB         = outARise & ~stb.wrB;
    stb.loadB   = evB & pendB;
    stb.decB    = evB & ~pendB & runB;
    stb.setB    = evB & ~pendB & runB & bAtOne;
  end

endmodule

// File: rtl/ctp_datapath.sv
module ctp_datapath
  import ctp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctpStrobes_t      stb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] cntA,
  output logic [WIDTH-1:0] cntB,
  output logic             outA,
  output logic             outB,
  output logic             aAtOne,
  output logic             bAtOne
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] holdA, holdB;

  assign aAtOne = (cntA == ONE);
  assign bAtOne = (cntB == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdA <= '0;
      holdB <= '0;
      cntA  <= '0;
      cntB  <= '0;
      outA  <= 1'b1;
      outB  <= 1'b0;
    end else begin
      // counter A, rate generator
      if (stb.wrA) holdA <= wrData;
      if (stb.loadA || stb.reloadA) cntA <= holdA;
      else if (stb.decA)            cntA <= cntA - ONE;
      if (stb.wrA || stb.loadA || stb.reloadA) outA <= 1'b1;
      else if (stb.dropA)                      outA <= 1'b0;
      // counter B, terminal-count one-shot
      if (stb.wrB) holdB <= wrData;
      if (stb.loadB)     cntB <= holdB;
      else if (stb.decB) cntB <= cntB - ONE;
      if (stb.wrB)       outB <= 1'b0;
      else if (stb.setB) outB <= 1'b1;
    end
  end

endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
  import ctp_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blankIn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] cntA,
  output logic [WIDTH-1:0] cntB,
  output logic             outA,
  output logic             outB
);

  ctpStrobes_t stb;
  logic blankRise, blankFall, outARise;
  logic aAtOne, bAtOne;

  ctp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .blankIn(blankIn), .wrEn(wrEn), .wrSel(wrSel),
    .outA(outA), .aAtOne(aAtOne), .bAtOne(bAtOne), .stb(stb),
    .blankRise(blankRise), .blankFall(blankFall), .outARise(outARise)
  );

  ctp_datapath #(.WIDTH(WIDTH)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .cntA(cntA), .cntB(cntB), .outA(outA), .outB(outB),
    .aAtOne(aAtOne), .bAtOne(bAtOne)
  );

endmodule

// File: rtl/ctp_checker.sv
module ctp_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrSel,
  input logic             blankRise,
  input logic             blankFall,
  input logic [WIDTH-1:0] cntA,
  input logic [WIDTH-1:0] cntB,
  input logic             outA,
  input logic             outB
);

  assert_cnta_on_blank_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cntA) |-> $past(blankRise));

  assert_outa_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outA) |-> ($past(blankFall) && cntA == WIDTH'(1)));

  assert_outa_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cntA != WIDTH'(1)) |-> outA);

  assert_cntb_on_outa_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cntB) |-> ($past(outA, 1) && !$past(outA, 2)));

  assert_outb_rise_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outB) |-> (cntB == '0));

  assert_outb_fall_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outB) |-> $past(wrEn && wrSel));

endmodule

bind cascade_timer_pair ctp_checker #(.WIDTH(WIDTH)) chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
  .blankRise(blankRise), .blankFall(blankFall),
  .cntA(cntA), .cntB(cntB), .outA(outA), .outB(outB)
);

// File: tb/cascade_timer_pair_test.sv
module cascade_timer_pair_test;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blankIn = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [W-1:0] wrData = '0;
  wire  [W-1:0] cntA, cntB;
  wire  outA, outB;

  always #4 clk = ~clk;  // 125 MHz

  cascade_timer_pair #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .blankIn(blankIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .cntA(cntA), .cntB(cntB), .outA(outA), .outB(outB)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mCntA, mCntB, mHoldA, mHoldB;
  bit mPendA, mRunA, mPendB, mRunB, mOutA, mOutB, mOutAPrev;
  bit hist[$];

  always @(posedge clk) begin
    bit br, bf, oRise, wa, wb;
    if (!rstN) begin
      mCntA = 0; mCntB = 0; mHoldA = 0; mHoldB = 0;
      mPendA = 0; mRunA = 0; mPendB = 0; mRunB = 0;
      mOutA = 1; mOutB = 0; mOutAPrev = 1;
      hist.delete();
      repeat (3) hist.push_back(1'b0);
    end else begin
      br = hist[1] && !hist[0];
      bf = !hist[1] && hist[0];
      oRise = mOutA && !mOutAPrev;
      mOutAPrev = mOutA;
      wa = wrEn && !wrSel;
      wb = wrEn && wrSel;
      if (wa) begin
        mHoldA = int'(wrData); mPendA = 1; mOutA = 1;
      end else if (br) begin
        if (mPendA) begin
          mCntA = mHoldA; mPendA = 0; mRunA = 1; mOutA = 1;
        end else if (mRunA) begin
          if (mCntA == 1) begin mCntA = mHoldA; mOutA = 1; end
          else mCntA = (mCntA + 65535) % 65536;
        end
      end else if (bf && mRunA && !mPendA && mCntA == 1) begin
        mOutA = 0;
      end
      if (wb) begin
        mHoldB = int'(wrData); mPendB = 1; mRunB = 0; mOutB = 0;
      end else if (oRise) begin
        if (mPendB) begin
          mCntB = mHoldB; mPendB = 0; mRunB = 1;
        end else if (mRunB) begin
          if (mCntB == 1) mOutB = 1;
          mCntB = (mCntB + 65535) % 65536;
        end
      end
      hist.push_back(blankIn);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R3 model cntA", int'(cntA), mCntA);
      chk("R4 model outA", int'(outA), int'(mOutA));
      chk("R6 model cntB", int'(cntB), mCntB);
      chk("R7 model outB", int'(outB), int'(mOutB));
    end
  end

  // ---------------- stimulus ----------------
  task automatic writeCount(input bit sel, input int val);
    wrSel = sel;
    wrData = W'(val);
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse();
    blankIn = 1'b1;
    repeat (6) @(negedge clk);
    blankIn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset cntA", int'(cntA), 0);
    chk("R1 reset cntB", int'(cntB), 0);
    chk("R1 reset outA", int'(outA), 1);
    chk("R1 reset outB", int'(outB), 0);

    // synchronizer latency and first-edge load
    writeCount(1'b0, 7);
    blankIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 cntA before second edge", int'(cntA), 0);
    @(negedge clk);
    chk("R2 cntA loaded not decremented", int'(cntA), 7);
    repeat (3) @(negedge clk);
    blankIn = 1'b0;
    repeat (6) @(negedge clk);

    // cascade: A = 2, B = 3
    writeCount(1'b0, 2);
    writeCount(1'b1, 3);
    pulse();  // 1
    chk("R2 A load on first pulse", int'(cntA), 2);
    pulse();  // 2
    chk("R3 A decremented", int'(cntA), 1);
    chk("R4 outA low at count 1", int'(outA), 0);
    pulse();  // 3
    chk("R3 A reloaded", int'(cntA), 2);
    chk("R4 outA high after reload", int'(outA), 1);
    chk("R6 B loaded on outA rise", int'(cntB), 3);
    pulse();  // 4
    chk("R8 B not yet decremented", int'(cntB), 3);
    pulse();  // 5
    chk("R8 B first decrement on fifth pulse", int'(cntB), 2);
    pulse(); pulse();  // 6, 7
    chk("R7 B at one", int'(cntB), 1);
    chk("R7 outB still low", int'(outB), 0);
    pulse(); pulse();  // 8, 9
    chk("R7 B at zero", int'(cntB), 0);
    chk("R7 outB high at zero", int'(outB), 1);
    pulse(); pulse();  // 10, 11
    chk("R9 B wrapped", int'(cntB), 65535);
    chk("R9 outB stays high", int'(outB), 1);

    // rewrite of A restarts the latency
    writeCount(1'b0, 3);
    pulse();
    chk("R10 rewrite loads new value", int'(cntA), 3);
    pulse();
    chk("R3 A counts after rewrite", int'(cntA), 2);
    pulse();
    chk("R4 outA low at one", int'(outA), 0);
    pulse();
    chk("R3 first period N+1", int'(cntA), 3);
    pulse(); pulse(); pulse();
    chk("R3 later period N", int'(cntA), 3);
    chk("R6 B steps per A period", int'(cntB), 65533);

    // zero means full range
    writeCount(1'b0, 0);
    pulse();
    chk("R5 zero loads as 0", int'(cntA), 0);
    pulse();
    chk("R5 zero then 65535", int'(cntA), 65535);

    // writing B: outB low at once, A untouched
    writeCount(1'b1, 5);
    chk("R7 write drops outB", int'(outB), 0);
    chk("R12 A untouched by B write", int'(cntA), 65535);
    chk("R10 B holds until its clock", int'(cntB), 65533);

    // A = 1 gives one outA rise per pulse
    writeCount(1'b0, 1);
    pulse();
    chk("R4 outA low with count 1", int'(outA), 0);
    pulse();
    chk("R6 B loaded", int'(cntB), 5);
    pulse();
    chk("R6 B decrements each pulse", int'(cntB), 4);

    repeat (4) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      finishRun();
    end
  end

endmodule